// File: doc/BRIEF.md
# Temperature Sensor Transaction Sequencer

This block drives a single-wire bit engine to take one complete temperature reading from one addressed sensor on a shared bus. A `start` pulse launches a two-phase transaction. In the first phase the sequencer resets the bus, selects the device by its 64-bit identity and tells it to begin a conversion. It then waits for a conversion time that depends on the chosen resolution. In the second phase it resets the bus again, selects the device again, asks for the scratchpad contents and shifts in the 16-bit reading. A successful read ends with a one-cycle write strobe that stores the reading in the sensor's RAM slot. If no device answers a reset, the transaction is abandoned and an error flag is raised.

The bit engine is reached through a request/done handshake. `eng_req` is a one-cycle pulse that carries an operation code and, for writes, the bit to send. The engine later pulses `eng_done`. On a reset, `eng_rbit` reports whether a presence pulse was seen. On a read, `eng_rbit` carries the sampled bit. There is only ever one request outstanding.

States: `S_IDLE`, `S_RST_ISSUE`, `S_RST_WAIT`, `S_TX_ISSUE`, `S_TX_WAIT`, `S_CONV_WAIT`, `S_RX_ISSUE`, `S_RX_WAIT`, `S_STORE`.

Transitions:
- IDLE→RST_ISSUE on `start`.
- RST_ISSUE→RST_WAIT always.
- RST_WAIT→TX_ISSUE on done with presence; RST_WAIT→IDLE on done without presence (abort).
- TX_ISSUE→TX_WAIT always.
- TX_WAIT→TX_ISSUE on done before the 80th bit.
- TX_WAIT→CONV_WAIT on the 80th done in the convert phase; TX_WAIT→RX_ISSUE on the 80th done in the read phase.
- CONV_WAIT→RST_ISSUE when the delay expires, which also switches to the read phase.
- RX_ISSUE→RX_WAIT always.
- RX_WAIT→RX_ISSUE on done before the 16th bit; RX_WAIT→STORE on the 16th done.
- STORE→IDLE always.

Top module: `tsense_sequencer`

## Requirements
- R1: After reset `eng_req`, `ram_we`, `presence_err` and `eng_wbit` are 0, and `reading` is 16'h0000.
- R2: A `start` in idle begins a phase with a reset request. `eng_op` encodes 2'b00 reset, 2'b01 write slot and 2'b10 read slot. A reset's `eng_done` with `eng_rbit`=1 means a device is present. Each transaction issues exactly two resets, one per phase.
- R3: After a present device answers a reset, the sequencer issues 80 write slots: 8'h55, then the 64-bit `dev_id`, then a command byte, each sent least-significant bit first.
- R4: The command byte is 8'h44 in the first (convert) phase and 8'hBE in the second (read) phase.
- R5: The second reset request is raised exactly N clock edges after the edge that samples `eng_done` for the last convert-phase write bit. N = (CLK_KHZ*375/4) << `res_sel`. The codes 0, 1, 2 and 3 stand for 9-, 10-, 11- and 12-bit resolution (93.75, 187.5, 375 and 750 ms). CLK_KHZ must be a multiple of 4.
- R6: The read phase issues exactly 16 read slots. The sampled bits are assembled least-significant bit first into `reading`.
- R7: After the 16th read completes, `ram_we` is high for exactly one cycle with the finished value on `reading`. There is exactly one strobe per successful transaction.
- R8: If a reset completes without presence in either phase, the sequencer returns to idle and issues no further requests. It raises `presence_err`, gives no `ram_we` and leaves `reading` unchanged. The flag stays high until the next accepted `start`, which clears it.
- R9: A `start` while a transaction is in progress is ignored: it causes no extra reset and does not change the slot sequence or the timing.
- R10: `eng_req` is a single-cycle pulse, and no new request is raised before the previous one's `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one transaction (accepted in idle only) |
| dev_id | input | 64 | Identity of the addressed sensor, captured at start |
| res_sel | input | 2 | Resolution code 0..3 (9..12 bit), captured at start |
| eng_done | input | 1 | Bit engine completed the current request |
| eng_rbit | input | 1 | Presence (reset) or sampled bit (read) from the engine |
| eng_req | output | 1 | One-cycle request to the bit engine |
| eng_op | output | 2 | Operation: 00 reset, 01 write, 10 read |
| eng_wbit | output | 1 | Bit to drive for a write request |
| reading | output | 16 | Assembled 16-bit reading |
| ram_we | output | 1 | One-cycle strobe that stores `reading` in the RAM slot |
| presence_err | output | 1 | No device answered a reset; held until the next start |

## Verification
The bench builds the sequencer with CLK_KHZ = 4, so the four conversion delays shrink to 375, 750, 1500 and 3000 cycles. At that size every resolution code can be timed to the exact edge within a short run, including the longest 12-bit wait. A behavioural bit-engine model answers every request. It records each write slot, so that both 80-bit selection frames can be compared bit by bit. It can withhold presence on the first or the second reset, which exercises both abort points and a start pulse that arrives during the conversion wait.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    typedef enum logic [3:0] {
        S_IDLE      = 4'd0,
        S_RST_ISSUE = 4'd1,
        S_RST_WAIT  = 4'd2,
        S_TX_ISSUE  = 4'd3,
        S_TX_WAIT   = 4'd4,
        S_CONV_WAIT = 4'd5,
        S_RX_ISSUE  = 4'd6,
        S_RX_WAIT   = 4'd7,
        S_STORE     = 4'd8
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } bus_op_t;

    localparam logic [7:0] CMD_SELECT  = 8'h55;
    localparam logic [7:0] CMD_CONVERT = 8'h44;
    localparam logic [7:0] CMD_FETCH   = 8'hBE;

endpackage

// File: rtl/tsense_conv_timer.sv
module tsense_conv_timer #(
    parameter int CLK_KHZ = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] res,
    output logic       expired
);
    localparam int BASE   = CLK_KHZ * 375 / 4;
    localparam int MAXC   = BASE * 8;
    localparam int W      = $clog2(MAXC + 1);
    localparam logic [W-1:0] BASE_W = W'(BASE);
    localparam logic [W-1:0] MAX_W  = W'(MAXC);

    logic [W-1:0] cnt_q;
    logic         running_q;

    assign expired = running_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else if (load) begin
            cnt_q     <= (BASE_W << res) - W'(1);
            running_q <= 1'b1;
        end else if (running_q) begin
            if (cnt_q == '0) running_q <= 1'b0;
            else             cnt_q     <= cnt_q - W'(1);
        end
    end

    // R5: count never exceeds the longest (12-bit) delay
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (cnt_q < MAX_W));
    // R5: expiry is a single-cycle event
    assert_expire_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
endmodule

// File: rtl/tsense_frame_mux.sv
module tsense_frame_mux #(
    parameter int ID_BITS = 64,
    parameter int IDX_W   = 7
) (
    input  logic [ID_BITS-1:0] id,
    input  logic               read_phase,
    input  logic [IDX_W-1:0]   idx,
    output logic               bit_out
);
    import tsense_pkg::*;
    localparam int FRAME_BITS = 8 + ID_BITS + 8;

    logic [7:0]            cmd;
    logic [FRAME_BITS-1:0] frame;

    assign cmd     = read_phase ? CMD_FETCH : CMD_CONVERT;
    assign frame   = {cmd, id, CMD_SELECT};
    assign bit_out = frame[idx];

    // R3: index always lands inside the frame
    always_comb begin
        assert_idx_in_frame_R3: assert (int'(idx) < FRAME_BITS);
    end
endmodule

// File: rtl/tsense_read_shift.sv
module tsense_read_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        value <= '0;
        else if (shift_en) value <= {bit_in, value[WIDTH-1:1]};
    end

    // R8: value moves only when a read bit arrives
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(value));
endmodule

// File: rtl/tsense_sequencer.sv
module tsense_sequencer #(
    parameter int CLK_KHZ   = 50000,
    parameter int ID_BITS   = 64,
    parameter int READ_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ID_BITS-1:0]   dev_id,
    input  logic [1:0]           res_sel,
    input  logic                 eng_done,
    input  logic                 eng_rbit,
    output logic                 eng_req,
    output logic [1:0]           eng_op,
    output logic                 eng_wbit,
    output logic [READ_BITS-1:0] reading,
    output logic                 ram_we,
    output logic                 presence_err
);
    import tsense_pkg::*;

    localparam int FRAME_BITS = 8 + ID_BITS + 8;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(READ_BITS - 1);

    seq_state_t           state_q, state_d;
    logic                 phase_q;
    logic [CNT_W-1:0]     bitcnt_q;
    logic [ID_BITS-1:0]   id_q;
    logic [1:0]           res_q;
    logic                 err_q;
    logic                 tx_last, rx_last;
    logic                 conv_load, conv_expired;
    logic                 frame_bit, rx_shift;
    bus_op_t              op_c;

    assign tx_last = (bitcnt_q == TX_LAST);
    assign rx_last = (bitcnt_q == RX_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_RST_ISSUE;
            S_RST_ISSUE: state_d = S_RST_WAIT;
            S_RST_WAIT:  if (eng_done) state_d = eng_rbit ? S_TX_ISSUE : S_IDLE;
            S_TX_ISSUE:  state_d = S_TX_WAIT;
            S_TX_WAIT:   if (eng_done) begin
                             if (!tx_last)     state_d = S_TX_ISSUE;
                             else if (phase_q) state_d = S_RX_ISSUE;
                             else              state_d = S_CONV_WAIT;
                         end
            S_CONV_WAIT: if (conv_expired) state_d = S_RST_ISSUE;
            S_RX_ISSUE:  state_d = S_RX_WAIT;
            S_RX_WAIT:   if (eng_done) state_d = rx_last ? S_STORE : S_RX_ISSUE;
            S_STORE:     state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= 1'b0;
            bitcnt_q <= '0;
            id_q     <= '0;
            res_q    <= 2'd0;
            err_q    <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                phase_q <= 1'b0;
                id_q    <= dev_id;
                res_q   <= res_sel;
                err_q   <= 1'b0;
            end
            if (state_q == S_RST_WAIT && eng_done) begin
                bitcnt_q <= '0;
                if (!eng_rbit) err_q <= 1'b1;
            end
            if (state_q == S_TX_WAIT && eng_done)
                bitcnt_q <= tx_last ? '0 : bitcnt_q + CNT_W'(1);
            if (state_q == S_RX_WAIT && eng_done)
                bitcnt_q <= bitcnt_q + CNT_W'(1);
            if (state_q == S_CONV_WAIT && conv_expired)
                phase_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        eng_req = 1'b0;
        op_c    = OP_RESET;
        eng_wbit = 1'b0;
        ram_we  = 1'b0;
        unique case (state_q)
            S_RST_ISSUE: eng_req = 1'b1;
            S_TX_ISSUE:  begin eng_req = 1'b1; op_c = OP_WRITE; eng_wbit = frame_bit; end
            S_TX_WAIT:   op_c = OP_WRITE;
            S_RX_ISSUE:  begin eng_req = 1'b1; op_c = OP_READ; end
            S_RX_WAIT:   op_c = OP_READ;
            S_STORE:     ram_we = 1'b1;
            default:     op_c = OP_RESET;
        endcase
    end

    assign eng_op       = op_c;
    assign presence_err = err_q;
    assign conv_load    = (state_q == S_TX_WAIT) && eng_done && tx_last && !phase_q;
    assign rx_shift     = (state_q == S_RX_WAIT) && eng_done;

    tsense_conv_timer #(.CLK_KHZ(CLK_KHZ)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(conv_load), .res(res_q), .expired(conv_expired)
    );

    tsense_frame_mux #(.ID_BITS(ID_BITS), .IDX_W(CNT_W)) u_frame (
        .id(id_q), .read_phase(phase_q), .idx(bitcnt_q), .bit_out(frame_bit)
    );

    tsense_read_shift #(.WIDTH(READ_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(rx_shift), .bit_in(eng_rbit), .value(reading)
    );

    // R10: request is a single-cycle pulse
    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);
    // R7: store strobe is a single-cycle pulse
    assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);
    // R7: store strobe follows a completed read slot
    assert_we_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(eng_done) && $past(eng_op) == 2'b10));
    // R8: error only rises after a reset answered without presence
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(presence_err) |-> $past(eng_done && !eng_rbit && eng_op == 2'b00));
    // R8: no store while the error flag is up
    assert_no_we_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        presence_err |-> !ram_we);
endmodule

// File: tb/tsense_sequencer_test.sv
module tsense_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 4;
    localparam int BASE       = CLK_KHZ * 375 / 4;

    typedef struct packed {
        logic [1:0]  res;
        logic [63:0] id;
        logic [15:0] temp;
    } vec_t;

    localparam vec_t VEC [0:3] = '{
        '{2'd0, 64'h28FF_1234_5678_9A01, 16'h0191},
        '{2'd1, 64'hA5A5_0F0F_C3C3_9669, 16'hFFFF},
        '{2'd2, 64'h0000_0000_0000_0001, 16'h0000},
        '{2'd3, 64'h8000_0000_0000_0000, 16'hFC90}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] dev_id = '0;
    logic [1:0]  res_sel = '0;
    logic        eng_done = 1'b0;
    logic        eng_rbit = 1'b0;
    logic        eng_req;
    logic [1:0]  eng_op;
    logic        eng_wbit;
    logic [15:0] reading;
    logic        ram_we;
    logic        presence_err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // engine model state
    logic [159:0] tx_vec;
    int tx_n, rst_cnt, rd_n, we_cnt;
    int fail_reset;          // 0 none, 1 first reset, 2 second reset
    logic [15:0] rd_val;
    logic [15:0] we_val;
    int t_cdone, t_rst2;

    tsense_sequencer #(.CLK_KHZ(CLK_KHZ)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_id(dev_id), .res_sel(res_sel),
        .eng_done(eng_done), .eng_rbit(eng_rbit), .eng_req(eng_req), .eng_op(eng_op),
        .eng_wbit(eng_wbit), .reading(reading), .ram_we(ram_we), .presence_err(presence_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ram_we) begin
            we_cnt = we_cnt + 1;
            we_val = reading;
        end
    end

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bit-engine model
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            eng_rbit = 1'b0;
            if (eng_req) begin
                logic resp;
                logic [1:0] op;
                op = eng_op;
                resp = 1'b0;
                if (op == 2'b00) begin
                    rst_cnt = rst_cnt + 1;
                    if (rst_cnt == 2) t_rst2 = cyc;
                    resp = (fail_reset != rst_cnt);
                end else if (op == 2'b01) begin
                    if (tx_n < 160) tx_vec[tx_n] = eng_wbit;
                    tx_n = tx_n + 1;
                end else begin
                    resp = rd_val[rd_n % 16];
                    rd_n = rd_n + 1;
                end
                @(negedge clk);
                if (op == 2'b01 && tx_n == 80) t_cdone = cyc;
                eng_done = 1'b1;
                eng_rbit = resp;
            end
        end
    end

    task automatic clear_model();
        tx_vec = '0; tx_n = 0; rst_cnt = 0; rd_n = 0; we_cnt = 0;
        we_val = '0; t_cdone = 0; t_rst2 = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_txn(input logic [63:0] id, input logic [1:0] res,
                           input logic [15:0] temp, input int fail, input bit extra_start);
        clear_model();
        dev_id = id; res_sel = res; rd_val = temp; fail_reset = fail;
        pulse_start();
        if (extra_start) begin
            while (tx_n < 80) @(negedge clk);
            repeat (20) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            if (we_cnt != 0 || presence_err) break;
        end
        repeat (30) @(negedge clk);
    endtask

    task automatic check_good(input vec_t v);
        logic [79:0] f0, f1;
        int n;
        f0 = tx_vec[79:0];
        f1 = tx_vec[159:80];
        n = BASE << v.res;
        chk("R2 reset count", 80'(rst_cnt), 80'd2);
        chk("R3 write slot count", 80'(tx_n), 80'd160);
        chk("R3 R4 convert frame", f0, {8'h44, v.id, 8'h55});
        chk("R3 R4 read frame", f1, {8'hBE, v.id, 8'h55});
        chk("R5 conversion gap", 80'(t_rst2 - t_cdone), 80'(n + 1));
        chk("R6 read slot count", 80'(rd_n), 80'd16);
        chk("R7 strobe count", 80'(we_cnt), 80'd1);
        chk("R6 R7 stored value", 80'(we_val), 80'(v.temp));
        chk("R8 no error", 80'(presence_err), 80'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_model();
        fail_reset = 0; rd_val = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 eng_req", 80'(eng_req), 80'd0);
        chk("R1 ram_we", 80'(ram_we), 80'd0);
        chk("R1 presence_err", 80'(presence_err), 80'd0);
        chk("R1 eng_wbit", 80'(eng_wbit), 80'd0);
        chk("R1 reading", 80'(reading), 80'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle no request", 80'(rst_cnt + tx_n), 80'd0);

        // table of vectors
        for (int k = 0; k < 4; k++) begin
            run_txn(VEC[k].id, VEC[k].res, VEC[k].temp, 0, 1'b0);
            check_good(VEC[k]);
        end

        // R8: no presence on first reset
        run_txn(64'h1111_2222_3333_4444, 2'd0, 16'h1234, 1, 1'b0);
        chk("R8 error on first reset", 80'(presence_err), 80'd1);
        chk("R8 no writes after abort", 80'(tx_n), 80'd0);
        chk("R8 one reset only", 80'(rst_cnt), 80'd1);
        chk("R8 no store", 80'(we_cnt), 80'd0);
        chk("R8 reading kept", 80'(reading), 80'(VEC[3].temp));

        // R8: no presence on second reset
        run_txn(64'h5555_6666_7777_8888, 2'd0, 16'h4321, 2, 1'b0);
        chk("R8 error on second reset", 80'(presence_err), 80'd1);
        chk("R8 convert frame only", 80'(tx_n), 80'd80);
        chk("R8 no reads", 80'(rd_n), 80'd0);
        chk("R8 no store phase two", 80'(we_cnt), 80'd0);
        chk("R8 reading kept phase two", 80'(reading), 80'(VEC[3].temp));
        repeat (50) @(negedge clk);
        chk("R8 flag held", 80'(presence_err), 80'd1);

        // R9: start during conversion ignored; also clears R8 flag on next start
        run_txn(64'h0123_4567_89AB_CDEF, 2'd1, 16'h5AA5, 0, 1'b1);
        check_good('{2'd1, 64'h0123_4567_89AB_CDEF, 16'h5AA5});
        chk("R9 no extra reset", 80'(rst_cnt), 80'd2);

        // R10: no stray requests while idle
        clear_model();
        repeat (40) @(negedge clk);
        chk("R10 idle quiet", 80'(rst_cnt + tx_n + rd_n), 80'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule